// File: doc/BRIEF.md
# CAN FD Dual-Rate Bit Timing Generator

This block turns the system clock into the bit timing of a CAN FD node. A prescaler cuts the clock into time quanta. A segment sequencer walks each bit through a one-quantum synchronization segment, a first phase segment (propagation plus phase 1) and a second phase segment. It emits a one-clock sample-point strobe at the end of the first phase segment and a one-clock end-of-bit strobe at the end of the second.

Two complete field sets are held at the inputs, one for the slow arbitration rate and one for the fast data rate, and every length is given as its value minus one. A phase-select input picks the set, and the choice takes effect at the next bit boundary. During the fast phase a secondary sample strobe marks the point where the node's own transmitted bit returns from the bus. Its position in quanta is a fixed offset plus a delay that is either measured elsewhere or given by hand. A hard-sync request restarts the bit at once. A resynchronization request with a signed phase error stretches the first phase segment or trims the second, bounded by the jump width.

Top module: `canfd_bittime_gen`

## Requirements
- R1: One quantum lasts (BRP+1) clocks of the active set. `tq_tick` is high for one clock at the last clock of every quantum.
- R2: A bit lasts 1 + (TSEG1+1) + (TSEG2+1) quanta. `bit_end` fires with the tick of its last quantum, and the next bit then starts in the sync segment (`seg_state` 0 = sync, 1 = phase 1, 2 = phase 2).
- R3: `sample_pt` fires with the tick that closes quantum number 1 + (TSEG1+1), counted from 1 at the start of the bit.
- R4: When the data set is active, the data prescaler and segment fields time the bit. With BRP=0, TSEG1=15 and TSEG2=3 the bit is 21 clocks long and the sample point falls on clock 17 of the bit.
- R5: `data_active` follows `data_sel` only on a `bit_end` cycle or on a hard-sync cycle. A change of `data_sel` in the middle of a bit leaves the current bit on its old timing.
- R6: While `hard_sync` is high, all strobes are low. In the following clock the block is at the first clock of the sync segment.
- R7: A late-edge request (`resync_late`=1) seen in the sync or phase 1 segment lengthens phase 1 by min(`resync_err`, SJW+1) quanta. A late-edge request made during phase 2 has no effect.
- R8: An early-edge request (`resync_late`=0) during phase 2 shortens phase 2 by min(`resync_err`, SJW+1) quanta. The bit never ends before the tick of the quantum that follows the request. Only the first accepted request in a bit has an effect.
- R9: In the data phase, `ssp_pt` fires with the tick that closes quantum number OFFSET+DELAY. DELAY is `tdc_meas` for mode code 2 and `tdc_manual` for mode code 1. Mode codes 0 and 3 disable the strobe, and a sum of zero gives no strobe. The strobe never fires in the nominal phase.
- R10: Every strobe is one clock wide, and `sample_pt` and `bit_end` never coincide.
- R11: During reset the block rests in the sync segment with the nominal set selected and all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| nom_brp | input | 8 | nominal prescaler minus one |
| nom_tseg1 | input | 8 | nominal phase 1 length minus one |
| nom_tseg2 | input | 7 | nominal phase 2 length minus one |
| nom_sjw | input | 7 | nominal jump width minus one |
| dat_brp | input | 8 | data prescaler minus one |
| dat_tseg1 | input | 5 | data phase 1 length minus one |
| dat_tseg2 | input | 4 | data phase 2 length minus one |
| dat_sjw | input | 4 | data jump width minus one |
| tdc_mode | input | 2 | 0 off, 1 manual delay, 2 measured delay, 3 off |
| tdc_offset | input | 7 | secondary sample offset in quanta |
| tdc_manual | input | 6 | manually set delay in quanta |
| tdc_meas | input | 6 | measured delay in quanta |
| data_sel | input | 1 | request data-rate timing |
| hard_sync | input | 1 | restart the bit |
| resync_req | input | 1 | one-clock resynchronization request |
| resync_late | input | 1 | 1 edge late (stretch), 0 edge early (trim) |
| resync_err | input | 8 | phase error magnitude in quanta |
| tq_tick | output | 1 | last clock of a quantum |
| sample_pt | output | 1 | sample point strobe |
| bit_end | output | 1 | end-of-bit strobe |
| ssp_pt | output | 1 | secondary sample point strobe |
| data_active | output | 1 | data set currently in use |
| seg_state | output | 2 | current segment |

## Verification
The bench builds the block with its default widths and with the delay compensation path generated. It can therefore drive both field sets at full width and exercise every delay mode code. Short field values keep a bit between 4 and 22 clocks long, so each strobe can be checked against a clock index counted from a hard sync. The same short bits make it possible to switch phase mid-bit, clamp a resynchronization step and land a second request in the same bit within a few hundred clocks.

// File: rtl/canfd_bt_pkg.sv
`timescale 1ns/1ps
package canfd_bt_pkg;
   typedef enum logic [1:0] {
      SEG_SYNC = 2'd0,
      SEG_PH1  = 2'd1,
      SEG_PH2  = 2'd2
   } seg_e;

   localparam logic [1:0] TDC_OFF    = 2'd0;
   localparam logic [1:0] TDC_MANUAL = 2'd1;
   localparam logic [1:0] TDC_AUTO   = 2'd2;
endpackage

// File: rtl/bt_tq_prescaler.sv
`timescale 1ns/1ps
module bt_tq_prescaler #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   // a shrinking divider mid-quantum closes the quantum at once (>=)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt <= '0;
      else if (restart || cnt >= div)  cnt <= '0;
      else                             cnt <= cnt + 1'b1;
   end

   assign tick = rst_n && !restart && (cnt >= div);
endmodule

// File: rtl/bt_seg_sequencer.sv
`timescale 1ns/1ps
module bt_seg_sequencer
   import canfd_bt_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int BQ_W  = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic [CNT_W-1:0] len1,
   input  logic [CNT_W-1:0] len2,
   input  logic [CNT_W-1:0] sjw_len,
   input  logic             rs_req,
   input  logic             rs_late,
   input  logic [CNT_W-1:0] rs_err,
   output logic             sample,
   output logic             bend,
   output logic [BQ_W-1:0]  bq,
   output logic [1:0]       seg
);
   seg_e             st;
   logic [CNT_W-1:0] q, ext, shr, adj;
   logic             used;
   logic [CNT_W:0]   q_inc, end1, q_sh;
   logic             last1, last2, seg_last, late_ok, early_ok;

   always_comb begin
      adj   = (rs_err < sjw_len) ? rs_err : sjw_len;
      q_inc = {1'b0, q} + 1'b1;
      end1  = {1'b0, len1} + {1'b0, ext};
      q_sh  = q_inc + {1'b0, shr};
      last1 = (q_inc >= end1);
      last2 = (q_sh >= {1'b0, len2});
      unique case (st)
         SEG_PH1: seg_last = last1;
         SEG_PH2: seg_last = last2;
         default: seg_last = 1'b1;
      endcase
   end

   assign sample   = tick && (st == SEG_PH1) && last1;
   assign bend     = tick && (st == SEG_PH2) && last2;
   assign late_ok  = rs_req && rs_late && !used && (st != SEG_PH2) && !sample;
   assign early_ok = rs_req && !rs_late && !used && (st == SEG_PH2) && !bend;
   assign seg      = st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= SEG_SYNC; q <= '0; bq <= '0;
         ext <= '0; shr <= '0; used <= 1'b0;
      end else if (restart) begin
         st <= SEG_SYNC; q <= '0; bq <= '0;
         ext <= '0; shr <= '0; used <= 1'b0;
      end else begin
         if (tick) begin
            bq <= bend ? '0 : bq + 1'b1;
            if (seg_last) begin
               q <= '0;
               unique case (st)
                  SEG_SYNC: st <= SEG_PH1;
                  SEG_PH1:  st <= SEG_PH2;
                  default:  st <= SEG_SYNC;
               endcase
            end else begin
               q <= q + 1'b1;
            end
         end
         if (bend) begin
            ext <= '0; shr <= '0; used <= 1'b0;
         end else if (late_ok) begin
            ext <= adj; used <= 1'b1;
         end else if (early_ok) begin
            shr <= adj; used <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/bt_ssp_gen.sv
`timescale 1ns/1ps
module bt_ssp_gen
   import canfd_bt_pkg::*;
#(
   parameter int TDCO_W = 7,
   parameter int TDCV_W = 6,
   parameter int BQ_W   = 11,
   parameter bit TDC_EN = 1'b1
) (
   input  logic              tick,
   input  logic              data_act,
   input  logic [1:0]        mode,
   input  logic [TDCO_W-1:0] offset,
   input  logic [TDCV_W-1:0] manual,
   input  logic [TDCV_W-1:0] meas,
   input  logic [BQ_W-1:0]   bq,
   output logic              ssp
);
   generate
      if (TDC_EN) begin : g_tdc
         logic              en;
         logic [TDCV_W-1:0] dv;
         logic [BQ_W-1:0]   pos;
         always_comb begin
            en  = (mode == TDC_MANUAL) || (mode == TDC_AUTO);
            dv  = (mode == TDC_AUTO) ? meas : manual;
            pos = BQ_W'(offset) + BQ_W'(dv);
         end
         assign ssp = en && data_act && tick && (pos != '0) && (bq == pos - 1'b1);
      end else begin : g_none
         assign ssp = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/canfd_bittime_gen.sv
`timescale 1ns/1ps
module canfd_bittime_gen #(
   parameter int BRP_W  = 8,
   parameter int NT1_W  = 8,
   parameter int NT2_W  = 7,
   parameter int NSJW_W = 7,
   parameter int DT1_W  = 5,
   parameter int DT2_W  = 4,
   parameter int DSJW_W = 4,
   parameter int TDCO_W = 7,
   parameter int TDCV_W = 6,
   parameter bit TDC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BRP_W-1:0]  nom_brp,
   input  logic [NT1_W-1:0]  nom_tseg1,
   input  logic [NT2_W-1:0]  nom_tseg2,
   input  logic [NSJW_W-1:0] nom_sjw,
   input  logic [BRP_W-1:0]  dat_brp,
   input  logic [DT1_W-1:0]  dat_tseg1,
   input  logic [DT2_W-1:0]  dat_tseg2,
   input  logic [DSJW_W-1:0] dat_sjw,
   input  logic [1:0]        tdc_mode,
   input  logic [TDCO_W-1:0] tdc_offset,
   input  logic [TDCV_W-1:0] tdc_manual,
   input  logic [TDCV_W-1:0] tdc_meas,
   input  logic              data_sel,
   input  logic              hard_sync,
   input  logic              resync_req,
   input  logic              resync_late,
   input  logic [NSJW_W:0]   resync_err,
   output logic              tq_tick,
   output logic              sample_pt,
   output logic              bit_end,
   output logic              ssp_pt,
   output logic              data_active,
   output logic [1:0]        seg_state
);
   localparam int CNT_W = NT1_W + 2;
   localparam int BQ_W  = NT1_W + 3;

   generate
      if (DT1_W > NT1_W || DT2_W > NT2_W || DSJW_W > NSJW_W)
         $error("data fields must not be wider than nominal fields");
      if (NT2_W > NT1_W || NSJW_W + 1 >= CNT_W)
         $error("phase 2 and jump width must fit the segment counter");
      if (TDCO_W + 1 >= BQ_W || TDCV_W + 1 >= BQ_W)
         $error("delay compensation fields too wide for bit counter");
   endgenerate

   logic [BRP_W-1:0] brp_a;
   logic [CNT_W-1:0] len1, len2, sjwl, err_e;
   logic [BQ_W-1:0]  bq;

   always_comb begin
      if (data_active) begin
         brp_a = dat_brp;
         len1  = CNT_W'(dat_tseg1) + 1'b1;
         len2  = CNT_W'(dat_tseg2) + 1'b1;
         sjwl  = CNT_W'(dat_sjw) + 1'b1;
      end else begin
         brp_a = nom_brp;
         len1  = CNT_W'(nom_tseg1) + 1'b1;
         len2  = CNT_W'(nom_tseg2) + 1'b1;
         sjwl  = CNT_W'(nom_sjw) + 1'b1;
      end
      err_e = CNT_W'(resync_err);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     data_active <= 1'b0;
      else if (hard_sync || bit_end)  data_active <= data_sel;
   end

   bt_tq_prescaler #(.DIV_W(BRP_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(hard_sync), .div(brp_a), .tick(tq_tick)
   );

   bt_seg_sequencer #(.CNT_W(CNT_W), .BQ_W(BQ_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .restart(hard_sync), .tick(tq_tick),
      .len1(len1), .len2(len2), .sjw_len(sjwl),
      .rs_req(resync_req), .rs_late(resync_late), .rs_err(err_e),
      .sample(sample_pt), .bend(bit_end), .bq(bq), .seg(seg_state)
   );

   bt_ssp_gen #(.TDCO_W(TDCO_W), .TDCV_W(TDCV_W), .BQ_W(BQ_W), .TDC_EN(TDC_EN)) u_ssp (
      .tick(tq_tick), .data_act(data_active), .mode(tdc_mode),
      .offset(tdc_offset), .manual(tdc_manual), .meas(tdc_meas),
      .bq(bq), .ssp(ssp_pt)
   );
endmodule

// File: rtl/bt_gen_chk.sv
`timescale 1ns/1ps
module bt_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       hard_sync,
   input logic       tq_tick,
   input logic       sample_pt,
   input logic       bit_end,
   input logic       ssp_pt,
   input logic       data_active,
   input logic [1:0] seg_state
);
   assert_sample_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_pt |-> tq_tick);

   assert_end_in_ph2_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_end |-> (tq_tick && seg_state == 2'd2));

   assert_switch_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_active != $past(data_active)) |-> ($past(bit_end) || $past(hard_sync)));

   assert_hsync_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hard_sync |=> (seg_state == 2'd0));

   assert_hsync_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hard_sync |-> !(tq_tick || sample_pt || bit_end || ssp_pt));

   assert_ssp_data_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ssp_pt |-> (data_active && tq_tick));

   assert_sample_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sample_pt |=> !sample_pt);

   assert_end_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bit_end |=> !bit_end);

   assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sample_pt, bit_end}));
endmodule

bind canfd_bittime_gen bt_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .hard_sync(hard_sync), .tq_tick(tq_tick),
   .sample_pt(sample_pt), .bit_end(bit_end), .ssp_pt(ssp_pt),
   .data_active(data_active), .seg_state(seg_state)
);

// File: tb/sim_canfd_bittime_gen.sv
`timescale 1ns/1ps
module sim_canfd_bittime_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] nom_brp = '0, nom_tseg1 = 8'd5, dat_brp = '0;
   logic [6:0] nom_tseg2 = 7'd2, nom_sjw = 7'd1, tdc_offset = '0;
   logic [4:0] dat_tseg1 = 5'd15;
   logic [3:0] dat_tseg2 = 4'd3, dat_sjw = 4'd3;
   logic [1:0] tdc_mode = 2'd0;
   logic [5:0] tdc_manual = '0, tdc_meas = '0;
   logic       data_sel = 1'b0, hard_sync = 1'b0;
   logic       resync_req = 1'b0, resync_late = 1'b0;
   logic [7:0] resync_err = '0;
   logic       tq_tick, sample_pt, bit_end, ssp_pt, data_active;
   logic [1:0] seg_state;
   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   canfd_bittime_gen u0 (
      .clk(clk), .rst_n(rst_n),
      .nom_brp(nom_brp), .nom_tseg1(nom_tseg1), .nom_tseg2(nom_tseg2), .nom_sjw(nom_sjw),
      .dat_brp(dat_brp), .dat_tseg1(dat_tseg1), .dat_tseg2(dat_tseg2), .dat_sjw(dat_sjw),
      .tdc_mode(tdc_mode), .tdc_offset(tdc_offset), .tdc_manual(tdc_manual), .tdc_meas(tdc_meas),
      .data_sel(data_sel), .hard_sync(hard_sync),
      .resync_req(resync_req), .resync_late(resync_late), .resync_err(resync_err),
      .tq_tick(tq_tick), .sample_pt(sample_pt), .bit_end(bit_end), .ssp_pt(ssp_pt),
      .data_active(data_active), .seg_state(seg_state)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_hsync();
      @(negedge clk); hard_sync = 1'b1;
      @(negedge clk); hard_sync = 1'b0;
      #1;
   endtask

   task automatic measure(input int ncyc, output int ks, output int ke,
                          output int kp, output int nt);
      ks = -1; ke = -1; kp = -1; nt = 0;
      for (int k = 0; k < ncyc; k++) begin
         if (tq_tick) nt++;
         if (sample_pt && ks < 0) ks = k;
         if (bit_end && ke < 0) ke = k;
         if (ssp_pt && kp < 0) kp = k;
         @(negedge clk); #1;
      end
   endtask

   task automatic run_resync(input int k1, input logic l1, input int e1,
                             input int k2, input logic l2, input int e2,
                             output int ks, output int ke);
      ks = -1; ke = -1;
      for (int k = 0; k < 15; k++) begin
         if (sample_pt && ks < 0) ks = k;
         if (bit_end && ke < 0) ke = k;
         resync_req = 1'b0;
         if (k == k1) begin resync_req = 1'b1; resync_late = l1; resync_err = 8'(e1); end
         else if (k == k2) begin resync_req = 1'b1; resync_late = l2; resync_err = 8'(e2); end
         @(negedge clk); #1;
      end
      resync_req = 1'b0;
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      #1;
      chk("R11 seg_state", int'(seg_state), 0);
      chk("R11 data_active", int'(data_active), 0);
      chk("R11 strobes", int'({tq_tick, sample_pt, bit_end, ssp_pt}), 0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic test_nominal();
      int ks, ke, kp, nt;
      nom_brp = 8'd1; nom_tseg1 = 8'd5; nom_tseg2 = 7'd2; data_sel = 1'b0;
      tdc_mode = 2'd2; tdc_offset = 7'd3;
      do_hsync();
      chk("R5 nominal selected", int'(data_active), 0);
      measure(20, ks, ke, kp, nt);
      chk("R3 nominal sample", ks, 13);
      chk("R2 nominal bit_end", ke, 19);
      chk("R1 ticks per bit", nt, 10);
      chk("R9 no ssp in nominal", kp, -1);
      measure(14, ks, ke, kp, nt);
      chk("R2 next bit sample", ks, 13);
   endtask

   task automatic test_prescale();
      int ks, ke, kp, nt;
      nom_brp = 8'd3; nom_tseg1 = 8'd1; nom_tseg2 = 7'd0;
      do_hsync();
      measure(16, ks, ke, kp, nt);
      chk("R1 prescale 4 sample", ks, 11);
      chk("R1 prescale 4 bit_end", ke, 15);
      chk("R1 prescale 4 ticks", nt, 4);
   endtask

   task automatic test_data();
      int ks, ke, kp, nt;
      data_sel = 1'b1; dat_brp = '0; dat_tseg1 = 5'd15; dat_tseg2 = 4'd3;
      tdc_mode = 2'd2; tdc_offset = 7'd17; tdc_meas = 6'd0;
      do_hsync();
      chk("R5 data selected on hard sync", int'(data_active), 1);
      measure(21, ks, ke, kp, nt);
      chk("R4 data sample", ks, 16);
      chk("R4 data bit_end", ke, 20);
      chk("R4 data ticks", nt, 21);
      chk("R9 ssp aligned with sample", kp, 16);
   endtask

   task automatic test_ssp();
      int ks, ke, kp, nt;
      data_sel = 1'b1; tdc_offset = 7'd5; tdc_manual = 6'd3; tdc_meas = 6'd9;
      tdc_mode = 2'd1; do_hsync(); measure(21, ks, ke, kp, nt);
      chk("R9 manual delay", kp, 7);
      tdc_mode = 2'd2; do_hsync(); measure(21, ks, ke, kp, nt);
      chk("R9 measured delay", kp, 13);
      tdc_mode = 2'd0; do_hsync(); measure(21, ks, ke, kp, nt);
      chk("R9 mode 0 off", kp, -1);
      tdc_mode = 2'd3; do_hsync(); measure(21, ks, ke, kp, nt);
      chk("R9 mode 3 off", kp, -1);
      tdc_mode = 2'd1; tdc_offset = '0; tdc_manual = '0; do_hsync(); measure(21, ks, ke, kp, nt);
      chk("R9 zero position", kp, -1);
   endtask

   task automatic test_switch();
      int e1 = -1, e2 = -1, s1 = -1, s2 = -1, da5 = -1, da6 = -1;
      nom_brp = '0; nom_tseg1 = 8'd2; nom_tseg2 = 7'd1;
      dat_brp = '0; dat_tseg1 = 5'd1; dat_tseg2 = 4'd0;
      tdc_mode = 2'd0; data_sel = 1'b0;
      do_hsync();
      for (int k = 0; k < 10; k++) begin
         if (k == 5) da5 = int'(data_active);
         if (k == 6) da6 = int'(data_active);
         if (sample_pt) begin if (s1 < 0) s1 = k; else if (s2 < 0) s2 = k; end
         if (bit_end)   begin if (e1 < 0) e1 = k; else if (e2 < 0) e2 = k; end
         if (k == 2) data_sel = 1'b1;
         @(negedge clk); #1;
      end
      chk("R5 old timing sample", s1, 3);
      chk("R5 old timing bit_end", e1, 5);
      chk("R5 no mid-bit switch", da5, 0);
      chk("R5 switch after boundary", da6, 1);
      chk("R5 data timing sample", s2, 8);
      chk("R5 data timing bit_end", e2, 9);
   endtask

   task automatic test_hsync();
      int ks, ke, kp, nt;
      nom_brp = 8'd1; nom_tseg1 = 8'd5; nom_tseg2 = 7'd2; data_sel = 1'b0;
      do_hsync();
      repeat (7) begin @(negedge clk); #1; end
      hard_sync = 1'b1; #0.5;
      chk("R6 tick suppressed", int'(tq_tick), 0);
      @(negedge clk); hard_sync = 1'b0; #1;
      chk("R6 restart in sync", int'(seg_state), 0);
      measure(20, ks, ke, kp, nt);
      chk("R6 sample after restart", ks, 13);
      chk("R6 bit_end after restart", ke, 19);
   endtask

   task automatic test_resync();
      int ks, ke;
      nom_brp = '0; nom_tseg1 = 8'd5; nom_tseg2 = 7'd2; nom_sjw = 7'd1; data_sel = 1'b0;
      do_hsync(); run_resync(2, 1'b1, 5, -1, 1'b0, 0, ks, ke);
      chk("R7 late clamped sample", ks, 8);
      chk("R7 late clamped bit_end", ke, 11);
      do_hsync(); run_resync(7, 1'b1, 2, -1, 1'b0, 0, ks, ke);
      chk("R7 late in phase 2 ignored", ke, 9);
      nom_sjw = 7'd3;
      do_hsync(); run_resync(2, 1'b1, 1, 3, 1'b1, 2, ks, ke);
      chk("R8 one request per bit sample", ks, 7);
      chk("R8 one request per bit end", ke, 10);
      do_hsync(); run_resync(7, 1'b0, 1, -1, 1'b0, 0, ks, ke);
      chk("R8 early sample unchanged", ks, 6);
      chk("R8 early shortens", ke, 8);
      do_hsync(); run_resync(7, 1'b0, 10, -1, 1'b0, 0, ks, ke);
      chk("R8 early floor next quantum", ke, 8);
   endtask

   initial begin
      test_reset();
      test_nominal();
      test_prescale();
      test_data();
      test_ssp();
      test_switch();
      test_hsync();
      test_resync();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(4 * 50000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule